// File: doc/BRIEF.md
# Dual-Mode Down Counter/Timer

This block is a down counter with a programmable reload value, driven by a one-cycle count enable. It works in one of two modes. In timer mode it runs freely and produces a square wave on its single output, with a frequency set by the reload value. In counter mode it waits for a start command, counts the reload value down, and then drives its output low and raises a terminal-count flag. The output stays low until a stop command.

Two configuration registers are written through a small write port: the reload value and the mode bit. Start and stop arrive as strobes. The count source is chosen outside the block and reaches it as the `cnt_tick` enable. The output is a plain function of the count state; no interrupt mask or enable gates it.

Top module: `ctmr_top`

## Requirements
- R1: After reset, `ct_out` is 1, `tc_flag` is 0, the mode is counter, and counting is stopped. Ticks have no visible effect until a start command.
- R2: Writing the mode register (`cfg_we`=1, `cfg_addr`=1) takes the mode from `cfg_wdata[0]`, where 1 is timer and 0 is counter. The write sets `ct_out` to 1, clears `tc_flag` and halts counter-mode counting. In timer mode it also loads the count from the reload value.
- R3: Writing the reload register (`cfg_we`=1, `cfg_addr`=0, value `cfg_wdata`) does not disturb a count in progress. The new value takes effect at the next load or reload.
- R4: In timer mode, with reload length L, `ct_out` toggles once every L ticks, starting high. The full period is 2L ticks. No start command is needed, and `tc_flag` stays 0.
- R5: In timer mode, a start command restarts the count from the reload value and sets `ct_out` high. A stop command has no effect.
- R6: In counter mode, a start command loads the reload value and begins counting. `ct_out` stays 1 until the L-th tick after the start. In the cycle after that tick, `ct_out` reads 0 and `tc_flag` reads 1.
- R7: After terminal count in counter mode, the counter keeps rolling over from all ones. `ct_out` stays 0 and `tc_flag` stays 1 through further ticks and start commands. Only a stop command or a mode write returns `ct_out` to 1 and clears `tc_flag`.
- R8: In counter mode, a stop command halts counting, so later ticks change nothing. The next start counts a full L ticks again.
- R9: A reload value of 0 counts as 65536 ticks.
- R10: Only cycles with `cnt_tick`=1 advance the count. In a single cycle, a mode write takes priority over start, stop and tick. In counter mode, stop takes priority over start, and a start takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 reload value, 1 mode |
| cfg_wdata | input | 16 | Write data; bit 0 is the mode bit |
| start_cmd | input | 1 | Start or restart strobe |
| stop_cmd | input | 1 | Stop strobe (counter mode only) |
| cnt_tick | input | 1 | One-cycle count enable from the selected source |
| ct_out | output | 1 | Counter/timer output |
| tc_flag | output | 1 | Terminal count reached (counter mode) |

## Verification
Directed runs cover the following cases:
- small reload lengths in timer mode, which separate a period of 2L from an off-by-one of 2L±2;
- counter runs with ticks spaced out by idle cycles, which show that only enabled cycles count;
- a stop in the middle of a count followed by a restart, which shows that the count reloads rather than resumes;
- a reload of 0 run to the end, which tells 65536 apart from 0 or 1.

A reload write during a count shows that the new value is deferred. Collisions of command, tick and mode write in the same cycle pin down the priority order. A long stretch of seeded random writes, commands and ticks is then compared cycle by cycle against a model in the bench, which counts the remaining ticks.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic {
    MODE_COUNTER = 1'b0,
    MODE_TIMER   = 1'b1
  } ct_mode_e;

  typedef enum logic {
    REG_RELOAD = 1'b0,
    REG_MODE   = 1'b1
  } ct_reg_e;
endpackage

// File: rtl/ctmr_cfg.sv
module ctmr_cfg
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] reload,
  output logic             timer_mode,
  output logic             mode_wr,
  output logic             mode_wr_timer
);
  ct_mode_e         mode_q;
  logic [CNT_W-1:0] reload_q;
  logic             reload_wr;

  assign mode_wr       = we && (ct_reg_e'(addr) == REG_MODE);
  assign reload_wr     = we && (ct_reg_e'(addr) == REG_RELOAD);
  assign mode_wr_timer = mode_wr && (ct_mode_e'(wdata[0]) == MODE_TIMER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_COUNTER;
      reload_q <= '0;
    end else begin
      if (mode_wr)   mode_q   <= ct_mode_e'(wdata[0]);
      if (reload_wr) reload_q <= wdata;
    end
  end

  assign reload     = reload_q;
  assign timer_mode = (mode_q == MODE_TIMER);

  // R3: the reload register changes only on its own write
  assert_reload_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_wr |=> $stable(reload_q));
endmodule

// File: rtl/ctmr_ctrl.sv
module ctmr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic timer_mode,
  input  logic mode_wr,
  input  logic mode_wr_timer,
  input  logic start,
  input  logic stop,
  input  logic tick,
  input  logic term,
  output logic stop_eff,
  output logic start_eff,
  output logic load,
  output logic count_en,
  output logic running
);
  logic run_q;
  logic active;

  // priority: mode write > stop (counter mode only) > start > tick
  assign stop_eff  = stop && !timer_mode && !mode_wr;
  assign start_eff = start && !mode_wr && !stop_eff;
  assign active    = timer_mode || run_q;
  assign count_en  = tick && active && !mode_wr && !stop_eff && !start_eff;
  assign load      = mode_wr_timer || start_eff || (term && timer_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run_q <= 1'b0;
    else if (mode_wr || stop_eff)    run_q <= 1'b0;
    else if (start_eff && !timer_mode) run_q <= 1'b1;
  end

  assign running = run_q;

  // R8: a counter-mode stop leaves the block halted
  assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_eff |=> !run_q);
  // R2: a mode write always halts counter-mode counting
  assert_modewr_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !run_q);
endmodule

// File: rtl/ctmr_down.sv
module ctmr_down #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  input  logic             load,
  input  logic             count_en,
  output logic             term
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // decrement with natural wrap: a reload of 0 spans 2**CNT_W ticks
  function automatic logic [CNT_W-1:0] dec_wrap(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign term = count_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= reload;
    else if (count_en) cnt_q <= dec_wrap(cnt_q);
  end

  // R10: without an enable or a load the count holds
  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !load) |=> $stable(cnt_q));
  // R9: the count never reaches the terminal value straight from a load of 0
  assert_zero_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && reload == '0) |=> cnt_q != LAST);
endmodule

// File: rtl/ctmr_outq.sv
module ctmr_outq (
  input  logic clk,
  input  logic rst_n,
  input  logic timer_mode,
  input  logic mode_wr,
  input  logic stop_eff,
  input  logic start_eff,
  input  logic term,
  output logic ct_out,
  output logic tc_flag
);
  logic out_q, tc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b1;
      tc_q  <= 1'b0;
    end else if (mode_wr || stop_eff) begin
      out_q <= 1'b1;
      tc_q  <= 1'b0;
    end else if (timer_mode) begin
      if (start_eff) out_q <= 1'b1;
      else if (term) out_q <= !out_q;
    end else if (term) begin
      out_q <= 1'b0;
      tc_q  <= 1'b1;
    end
  end

  assign ct_out  = out_q;
  assign tc_flag = tc_q;

  // R7: a raised flag always comes with a low output
  assert_tc_low_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> !out_q);
  // R7: in counter mode the output rises only through stop or a mode write
  assert_rise_by_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_mode && $rose(out_q)) |-> $past(stop_eff || mode_wr));
  // R4: timer mode never raises the flag
  assert_timer_no_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_mode |-> !tc_q);
  // R4: each timer terminal event flips the output
  assert_timer_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_mode && term && !start_eff && !mode_wr) |=> (out_q != $past(out_q)));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             cnt_tick,
  output logic             ct_out,
  output logic             tc_flag
);
  logic [CNT_W-1:0] reload;
  logic timer_mode, mode_wr, mode_wr_timer;
  logic stop_eff, start_eff, load, count_en, running, term;

  ctmr_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .reload(reload), .timer_mode(timer_mode), .mode_wr(mode_wr),
    .mode_wr_timer(mode_wr_timer)
  );

  ctmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .timer_mode(timer_mode), .mode_wr(mode_wr),
    .mode_wr_timer(mode_wr_timer), .start(start_cmd), .stop(stop_cmd),
    .tick(cnt_tick), .term(term), .stop_eff(stop_eff), .start_eff(start_eff),
    .load(load), .count_en(count_en), .running(running)
  );

  ctmr_down #(.CNT_W(CNT_W)) u_down (
    .clk(clk), .rst_n(rst_n), .reload(reload), .load(load),
    .count_en(count_en), .term(term)
  );

  ctmr_outq u_outq (
    .clk(clk), .rst_n(rst_n), .timer_mode(timer_mode), .mode_wr(mode_wr),
    .stop_eff(stop_eff), .start_eff(start_eff), .term(term),
    .ct_out(ct_out), .tc_flag(tc_flag)
  );

  // R1: a stopped counter-mode block ignores ticks
  assert_idle_ignores_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_mode && !running && !cfg_we && !start_cmd && !stop_cmd)
      |=> ($stable(ct_out) && $stable(tc_flag)));
endmodule

// File: tb/sim_ctmr_top.sv
module sim_ctmr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_addr = 1'b0, start_cmd = 1'b0, stop_cmd = 1'b0, cnt_tick = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic ct_out, tc_flag;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = !clk;

  ctmr_top u0 (.*);

  // reference model: remaining ticks until the terminal event
  int  m_pre, m_rem;
  bit  m_timer, m_run, m_out, m_tc;

  function automatic int span(input int p);
    return (p == 0) ? 65536 : p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_rem = 0; m_timer = 0; m_run = 0; m_out = 1; m_tc = 0;
    end else begin
      int old_pre;
      old_pre = m_pre;
      if (cfg_we && cfg_addr) begin
        m_timer = cfg_wdata[0]; m_run = 0; m_out = 1; m_tc = 0;
        if (m_timer) m_rem = span(old_pre);
      end else begin
        if (cfg_we) m_pre = cfg_wdata;
        if (!m_timer) begin
          if (stop_cmd) begin m_run = 0; m_out = 1; m_tc = 0; end
          else if (start_cmd) begin m_run = 1; m_rem = span(old_pre); end
          else if (cnt_tick && m_run) begin
            if (m_rem == 1) begin m_out = 0; m_tc = 1; m_rem = 65536; end
            else m_rem = m_rem - 1;
          end
        end else begin
          if (start_cmd) begin m_rem = span(old_pre); m_out = 1; end
          else if (cnt_tick) begin
            if (m_rem == 1) begin m_out = !m_out; m_rem = span(old_pre); end
            else m_rem = m_rem - 1;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b at cycle %0d", req, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk({tag, " out"}, ct_out, m_out);
      chk({tag, " tc"}, tc_flag, m_tc);
    end
  end

  task automatic step(input bit we, input bit a, input int d,
                      input bit st, input bit sp, input bit tk);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = 16'(d);
    start_cmd = st; stop_cmd = sp; cnt_tick = tk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1 reset";
    idle(1); chk("R1 reset out", ct_out, 1'b1); chk("R1 reset tc", tc_flag, 1'b0);
    ticks(5); chk("R1 idle ticks out", ct_out, 1'b1);

    tag = "R6 counter";
    step(1, 0, 3, 0, 0, 0); step(0, 0, 0, 1, 0, 0);
    ticks(2); idle(1); chk("R6 before terminal", ct_out, 1'b1);
    ticks(1); idle(1); chk("R6 terminal out", ct_out, 1'b0); chk("R6 terminal tc", tc_flag, 1'b1);

    tag = "R7 hold low";
    ticks(10); step(0, 0, 0, 1, 0, 0); ticks(4); idle(1);
    chk("R7 low after rollover", ct_out, 1'b0);
    step(0, 0, 0, 0, 1, 0); idle(1);
    chk("R7 stop raises out", ct_out, 1'b1); chk("R7 stop clears tc", tc_flag, 1'b0);

    tag = "R10 spaced ticks";
    step(1, 0, 4, 0, 0, 0); step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin step(0, 0, 0, 0, 0, 1); idle(3); end
    chk("R10 spaced terminal", ct_out, 1'b0);
    step(0, 0, 0, 0, 1, 0);

    tag = "R8 stop restart";
    step(0, 0, 0, 1, 0, 0); ticks(2); step(0, 0, 0, 0, 1, 0); ticks(6); idle(1);
    chk("R8 halted out", ct_out, 1'b1);
    step(0, 0, 0, 1, 0, 0); ticks(3); idle(1); chk("R8 full span", ct_out, 1'b1);
    ticks(1); idle(1); chk("R8 restart terminal", ct_out, 1'b0);

    tag = "R10 collisions";
    step(0, 0, 0, 1, 1, 1); idle(1); chk("R10 stop wins", tc_flag, 1'b0);
    ticks(8); chk("R10 still stopped", ct_out, 1'b1);
    step(0, 0, 0, 1, 0, 0); ticks(3); step(1, 1, 0, 1, 0, 1); idle(1);
    chk("R10 mode write wins", ct_out, 1'b1);

    tag = "R4 timer";
    step(1, 0, 3, 0, 0, 0); step(1, 1, 1, 0, 0, 0);
    ticks(3); idle(1); chk("R4 first toggle", ct_out, 1'b0);
    ticks(3); idle(1); chk("R4 second toggle", ct_out, 1'b1);
    chk("R4 no tc", tc_flag, 1'b0);
    tag = "R3 deferred reload";
    step(1, 0, 5, 0, 0, 0); ticks(3); idle(1); chk("R3 old span used", ct_out, 1'b0);
    ticks(5); idle(1); chk("R3 new span", ct_out, 1'b1);

    tag = "R5 timer start/stop";
    ticks(2); step(0, 0, 0, 0, 1, 0); ticks(3); idle(1); chk("R5 stop ignored", ct_out, 1'b0);
    step(0, 0, 0, 1, 0, 0); idle(1); chk("R5 start sets high", ct_out, 1'b1);
    ticks(4); idle(1); chk("R5 restart span", ct_out, 1'b1);
    ticks(1); idle(1); chk("R5 restart toggle", ct_out, 1'b0);

    tag = "R2 mode back";
    step(1, 1, 0, 0, 0, 0); idle(1); chk("R2 counter mode out", ct_out, 1'b1);
    ticks(6); chk("R2 counter stopped", ct_out, 1'b1);

    tag = "R9 zero reload";
    step(1, 0, 0, 0, 0, 0); step(0, 0, 0, 1, 0, 0);
    ticks(65535); idle(1); chk("R9 not yet", ct_out, 1'b1);
    ticks(1); idle(1); chk("R9 65536 ticks", ct_out, 1'b0);
    step(0, 0, 0, 0, 1, 0);

    tag = "R10 random";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) step(1, 0, $urandom_range(1, 7), 0, 0, $urandom_range(0, 1));
      else if (r < 5) step(1, 1, $urandom_range(0, 1), 0, 0, 0);
      else if (r < 8) step(0, 0, 0, 1, $urandom_range(0, 1), $urandom_range(0, 1));
      else if (r < 10) step(0, 0, 0, 0, 1, $urandom_range(0, 1));
      else step(0, 0, 0, 0, 0, $urandom_range(0, 1));
    end
    idle(2);
    finish_run();
  end
endmodule